// File: doc/BRIEF.md
# ADC Conversion Result Register Bank

This block stores the results produced by an eight-channel, 10-bit analog-to-digital converter and presents them on a simple synchronous read port. A converter sequencer, outside this block, signals each finished conversion with a one-cycle strobe. The strobe carries a channel index and the 10-bit value. The sequencer may issue these strobes one at a time (software-triggered conversions) or on every cycle (burst scans over one or several channels).

Each channel owns a result register. It holds the latest value, a completion flag and an overrun flag. An additional summary register tracks the latest conversion from any channel and records which channel produced it. Both flags clear when their register is read.

The central property is that clear-on-read never loses a completion. When a read and a new result hit the same register in the same cycle, the read returns the previous content. The completion flag then remains set for the new value.

Top module: `adc_result_bank`

## Requirements
- R1: After a synchronous active-low reset, every register reads as zero and `rd_data` is zero.
- R2: A completion strobe for channel c stores the value in that channel's register and sets its completion flag. A read of address c then returns the value in bits [15:6] and the completion flag in bit 31.
- R3: A read returns the register content from before the read in `rd_data` on the following cycle. It clears the completion flag and the overrun flag of that register, and the stored value is kept.
- R4: A completion that arrives while the register's completion flag is still set, with no read of that register in the same cycle, sets the overrun flag (bit 30). The register keeps the newest value.
- R5: Address 8 is the summary register. It holds the newest value from any channel in bits [15:6] and that channel's index in bits [26:24]. Its completion and overrun flags follow the same rules as R2 to R4.
- R6: When a read of a register and a completion for that same register fall in the same cycle, the read returns the old content. Afterwards the register holds the new value with the completion flag set and the overrun flag clear.
- R7: A read of a channel register leaves the summary flags unchanged, and a read of the summary register leaves all channel flags unchanged. A completion changes only its own channel register and the summary register.
- R8: Completions on consecutive cycles, as in a burst scan, are all captured, each in its own channel register.
- R9: A read of addresses 9 to 15 returns zero and changes no register.
- R10: `rd_data` holds its value in every cycle in which `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_valid | input | 1 | Conversion-complete strobe |
| cmp_chan | input | 3 | Channel index of the finished conversion |
| cmp_value | input | 10 | Conversion result |
| rd_en | input | 1 | Register read request |
| rd_addr | input | 4 | Read address: 0-7 channel registers, 8 summary register |
| rd_data | output | 32 | Read word, valid the cycle after `rd_en` |

## Verification
A register read, with its flag clear, and a hardware completion, with its flag set, can fall on the same register in the same cycle. This happens for a channel register and for the summary register. The bench provokes this collision on purpose for every channel and for the summary register. It also produces the collision at random during long mixed streams of strobes and reads. In every case the word returned by the colliding read must be the old content. A follow-up read must then show the new value with the completion flag set and the overrun flag clear, as computed by an arithmetic model kept in the bench.

// File: rtl/adc_rb_pkg.sv
// Package: shared geometry of the ADC result register bank.
// Assumes the result field sits below the channel field and the flags sit on top.
package adc_rb_pkg;
    localparam int WORD_W   = 32;
    localparam int RES_LSB  = 6;
    localparam int CHAN_LSB = 24;
    localparam int OVR_BIT  = 30;
    localparam int DONE_BIT = 31;
endpackage

// File: rtl/adc_rb_slot.sv
// Module: one result register with completion and overrun flags.
// A completion (set_i) always wins over a same-cycle clear-on-read (clr_i).
// Assumes set_i and clr_i are single-cycle qualified pulses.
module adc_rb_slot #(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_i,
    input  logic [RES_W-1:0] value_i,
    input  logic             clr_i,
    output logic             done_o,
    output logic             ovr_o,
    output logic [RES_W-1:0] value_o
);
    logic             done_q;
    logic             ovr_q;
    logic [RES_W-1:0] value_q;

    // Update value and flags; a completion takes priority over the read clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q  <= 1'b0;
            ovr_q   <= 1'b0;
            value_q <= '0;
        end else if (set_i) begin
            value_q <= value_i;
            done_q  <= 1'b1;
            ovr_q   <= clr_i ? 1'b0 : (done_q | ovr_q);
        end else if (clr_i) begin
            done_q  <= 1'b0;
            ovr_q   <= 1'b0;
        end
    end

    assign done_o  = done_q;
    assign ovr_o   = ovr_q;
    assign value_o = value_q;

    assert_set_captured_R2: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> (done_q && value_q == $past(value_i)));
    assert_clear_on_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> (!done_q && !ovr_q && $stable(value_q)));
    assert_overrun_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !clr_i && done_q) |=> ovr_q);
    assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && clr_i) |=> (done_q && !ovr_q));
    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !clr_i) |=> ($stable(done_q) && $stable(ovr_q) && $stable(value_q)));
endmodule

// File: rtl/adc_rb_readmux.sv
// Module: assembles the 32-bit read word for the addressed register.
// Assumes index NUM_CH in the flag/value arrays is the summary register.
// Addresses above NUM_CH yield an all-zero word.
module adc_rb_readmux
    import adc_rb_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int RES_W  = 10,
    parameter int CH_W   = 3,
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0]            addr_i,
    input  logic [NUM_CH:0]              done_i,
    input  logic [NUM_CH:0]              ovr_i,
    input  logic [NUM_CH:0][RES_W-1:0]   value_i,
    input  logic [CH_W-1:0]              gchan_i,
    output logic [WORD_W-1:0]            word_o
);
    // Select the addressed register and place its fields into the word.
    always_comb begin
        word_o = '0;
        for (int i = 0; i <= NUM_CH; i++) begin
            if (addr_i == ADDR_W'(i)) begin
                word_o[DONE_BIT]                  = done_i[i];
                word_o[OVR_BIT]                   = ovr_i[i];
                word_o[RES_LSB +: RES_W]          = value_i[i];
                if (i == NUM_CH) begin
                    word_o[CHAN_LSB +: CH_W]      = gchan_i;
                end
            end
        end
    end
endmodule

// File: rtl/adc_result_bank.sv
// Module: top of the ADC result register bank.
// Holds NUM_CH channel registers plus one summary register, with a registered
// read port whose reads clear the flags of the addressed register.
// Assumes at most one completion strobe per cycle from the sequencer.
module adc_result_bank
    import adc_rb_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int RES_W  = 10
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  cmp_valid,
    input  logic [$clog2(NUM_CH)-1:0]             cmp_chan,
    input  logic [RES_W-1:0]                      cmp_value,
    input  logic                                  rd_en,
    input  logic [$clog2(NUM_CH+1)-1:0]           rd_addr,
    output logic [WORD_W-1:0]                     rd_data
);
    localparam int CH_W   = $clog2(NUM_CH);
    localparam int ADDR_W = $clog2(NUM_CH + 1);
    localparam int GLB    = NUM_CH;

    logic [NUM_CH:0]            set_v;
    logic [NUM_CH:0]            clr_v;
    logic [NUM_CH:0]            done_v;
    logic [NUM_CH:0]            ovr_v;
    logic [NUM_CH:0][RES_W-1:0] value_v;
    logic [CH_W-1:0]            gchan_q;
    logic [WORD_W-1:0]          word_c;

    // Decode completion strobes and read clears per register slot.
    always_comb begin
        for (int i = 0; i < NUM_CH; i++) begin
            set_v[i] = cmp_valid && (cmp_chan == CH_W'(i));
            clr_v[i] = rd_en && (rd_addr == ADDR_W'(i));
        end
        set_v[GLB] = cmp_valid;
        clr_v[GLB] = rd_en && (rd_addr == ADDR_W'(GLB));
    end

    // One result slot per channel plus the summary slot.
    for (genvar g = 0; g <= NUM_CH; g++) begin : g_slot
        adc_rb_slot #(.RES_W(RES_W)) slot_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_i   (set_v[g]),
            .value_i (cmp_value),
            .clr_i   (clr_v[g]),
            .done_o  (done_v[g]),
            .ovr_o   (ovr_v[g]),
            .value_o (value_v[g])
        );
    end

    // Record the source channel of the newest conversion for the summary word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gchan_q <= '0;
        end else if (cmp_valid) begin
            gchan_q <= cmp_chan;
        end
    end

    adc_rb_readmux #(
        .NUM_CH (NUM_CH),
        .RES_W  (RES_W),
        .CH_W   (CH_W),
        .ADDR_W (ADDR_W)
    ) mux_i (
        .addr_i  (rd_addr),
        .done_i  (done_v),
        .ovr_i   (ovr_v),
        .value_i (value_v),
        .gchan_i (gchan_q),
        .word_o  (word_c)
    );

    // Capture the pre-update register content on each read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= word_c;
        end
    end

    assert_summary_chan_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid |=> (gchan_q == $past(cmp_chan) && done_v[GLB]));
    assert_bad_addr_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr > ADDR_W'(GLB)) |=> (rd_data == '0));
    assert_hold_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
    assert_single_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(set_v[NUM_CH-1:0]) <= 1);
endmodule

// File: tb/adc_result_bank_tb.sv
// Bench: sweeps channels and values and runs a long mixed stream.
// Expected words come from an arithmetic model of the requirements.
module adc_result_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmp_valid = 1'b0;
    logic [2:0]  cmp_chan = '0;
    logic [9:0]  cmp_value = '0;
    logic        rd_en = 1'b0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;

    int total = 0;
    int bad = 0;
    bit m_done [0:8];
    bit m_ovr  [0:8];
    int m_val  [0:8];
    int m_gch;
    logic [31:0] last_exp;

    always #5 clk = ~clk;

    adc_result_bank dut_i (
        .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_chan(cmp_chan),
        .cmp_value(cmp_value), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    function automatic logic [31:0] model_word(int a);
        logic [31:0] w;
        if (a > 8) return 32'd0;
        w = (32'(m_done[a]) << 31) | (32'(m_ovr[a]) << 30) | (32'(m_val[a]) << 6);
        if (a == 8) w = w | (32'(m_gch) << 24);
        return w;
    endfunction

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%08h exp=%08h", tag, got, exp);
        end
    endtask

    // One cycle: drive at negedge, update model, check rd_data at next negedge.
    task automatic cyc(bit cv, int ch, int val, bit re, int ad, string tag);
        logic [31:0] exp;
        cmp_valid = cv; cmp_chan = 3'(ch); cmp_value = 10'(val);
        rd_en = re; rd_addr = 4'(ad);
        exp = re ? model_word(ad) : last_exp;
        for (int i = 0; i <= 8; i++) begin
            bit s, c;
            s = cv && (i == 8 || i == ch);
            c = re && (ad == i);
            if (s) begin
                m_val[i] = val;
                m_ovr[i] = c ? 1'b0 : (m_done[i] | m_ovr[i]);
                m_done[i] = 1'b1;
            end else if (c) begin
                m_done[i] = 1'b0;
                m_ovr[i] = 1'b0;
            end
        end
        if (cv) m_gch = ch;
        last_exp = exp;
        @(posedge clk);
        @(negedge clk);
        cmp_valid = 1'b0; rd_en = 1'b0;
        check(tag, rd_data, exp);
    endtask

    initial begin
        for (int i = 0; i <= 8; i++) begin m_done[i] = 0; m_ovr[i] = 0; m_val[i] = 0; end
        m_gch = 0;
        last_exp = '0;
        repeat (3) @(negedge clk);
        check("R1 rd_data in reset", rd_data, 32'd0);
        rst_n = 1'b1;
        for (int a = 0; a <= 8; a++) cyc(0, 0, 0, 1, a, "R1 reset read");

        // R2/R3: store, read, re-read for each channel and value pattern
        for (int ch = 0; ch < 8; ch++) begin
            for (int k = 0; k < 5; k++) begin
                int v;
                v = (k == 0) ? 0 : (k == 1) ? 1023 : (k == 2) ? 341 : (k == 3) ? 682 : (ch * 123 + 7) % 1024;
                cyc(1, ch, v, 0, 0, "R2 store");
                cyc(0, 0, 0, 1, ch, "R2 read after completion");
                cyc(0, 0, 0, 1, ch, "R3 re-read cleared");
                cyc(0, 0, 0, 1, 8, "R5 summary read");
            end
        end
        // R4: overrun on channel and summary
        for (int ch = 0; ch < 8; ch++) begin
            cyc(1, ch, 100 + ch, 0, 0, "R4 first");
            cyc(1, ch, 200 + ch, 0, 0, "R4 second");
            cyc(0, 0, 0, 1, ch, "R4 overrun channel");
            cyc(0, 0, 0, 1, 8, "R4 overrun summary");
        end
        // R6: same-cycle read and completion on channel and on summary
        for (int ch = 0; ch < 8; ch++) begin
            cyc(1, ch, 300 + ch, 0, 0, "R6 prime");
            cyc(1, ch, 400 + ch, 1, ch, "R6 collide channel returns old");
            cyc(0, 0, 0, 1, ch, "R6 channel keeps done");
            cyc(1, (ch + 1) % 8, 500 + ch, 1, 8, "R6 collide summary returns old");
            cyc(0, 0, 0, 1, 8, "R6 summary keeps done");
        end
        // R7: read of channel leaves summary, read of summary leaves channels
        cyc(1, 3, 77, 0, 0, "R7 prime");
        cyc(0, 0, 0, 1, 3, "R7 read channel");
        cyc(0, 0, 0, 1, 8, "R7 summary still done");
        cyc(1, 5, 88, 0, 0, "R7 prime2");
        cyc(0, 0, 0, 1, 8, "R7 read summary");
        cyc(0, 0, 0, 1, 5, "R7 channel still done");
        cyc(0, 0, 0, 1, 4, "R7 untouched channel");
        // R8: burst of back-to-back completions
        for (int ch = 0; ch < 8; ch++) cyc(1, ch, 900 + ch, 0, 0, "R8 burst");
        for (int ch = 0; ch < 8; ch++) cyc(0, 0, 0, 1, ch, "R8 burst captured");
        // R9: unused addresses
        cyc(1, 2, 55, 0, 0, "R9 prime");
        for (int a = 9; a < 16; a++) cyc(0, 0, 0, 1, a, "R9 unused address zero");
        cyc(0, 0, 0, 1, 2, "R9 nothing changed");
        // R10: hold while idle
        cyc(0, 0, 0, 0, 0, "R10 hold");
        cyc(1, 1, 12, 0, 0, "R10 hold with completion");
        // Mixed stream
        begin
            logic [15:0] lf;
            lf = 16'hACE1;
            for (int n = 0; n < 4000; n++) begin
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                cyc(lf[0], int'(lf[3:1]), int'(lf[13:4]) , lf[14], int'(lf[15] ? 4'd8 : {1'b0, lf[7:5]}),
                    "R6 mixed stream");
            end
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired got=1 exp=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule